// File: doc/BRIEF.md
# Wake-Up and Settling Sequencer for a Decimating Converter

This block is the control sequencer on the device side of a decimating sampling converter. It runs on the master clock and watches an active-low input that both synchronises and powers down the converter. While that input is low the block holds the converter in power-down and marks the output register invalid. After the input is released, the block steps through wake-up, filter reset and first sample on consecutive clock edges. It then counts a settling interval that scales with the selected decimation rate.

When settling completes, the active-low ready output falls and a one-cycle result strobe fires. From then on a new result appears once per output period, which is eight times the decimation rate. Ready rises for four clocks just before each output-register update. Pulling the sync input low at any point aborts the sequence and starts again from power-down. The decimation rate is a two-bit configuration input, captured on the wake-up edge.

Top module: `wake_settle_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, pwr_down is 1, rdy_n is 1, and filt_rst, samp_take and new_result are 0.
- R2: Every rising edge that samples sync_pd_n low makes pwr_down 1, rdy_n 1, and all three strobes 0 for the following cycle. This state holds for as long as the input stays low.
- R3: On the first rising edge (E0) that samples sync_pd_n high after power-down, pwr_down falls to 0.
- R4: filt_rst is high for exactly the one cycle that follows edge E1, the edge after E0.
- R5: samp_take is high for exactly the one cycle that follows edge E2, the edge after E1.
- R6: The rate code dec_sel selects the decimation rate as follows: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 32. rdy_n stays 1 until edge E_T and falls on that edge. T is rate*74 + 2 + EXTRA_DLY, which with the default EXTRA_DLY of 2 gives 596, 1188 or 2372.
- R7: After settling, rdy_n is 1 for exactly the four cycles before each later result edge and 0 at all other times.
- R8: new_result is high for one cycle after each edge E_T + k*P (k = 0, 1, ...), where P = 8*rate. rdy_n is 0 in every cycle in which new_result is 1.
- R9: A low sync_pd_n during settling or during periodic output aborts the sequence, giving pwr_down 1 and rdy_n 1 on the next cycle. The next release replays the full sequence from R3.
- R10: dec_sel is sampled only on edge E0. Changes to it after E0 have no effect on the timing until the next wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all events occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pd_n | input | 1 | Active-low sync / power-down request |
| dec_sel | input | 2 | Decimation rate code (0:8, 1:16, 2:32, 3:32) |
| pwr_down | output | 1 | High while the converter is held powered down |
| filt_rst | output | 1 | One-cycle filter reset strobe |
| samp_take | output | 1 | One-cycle first-sample strobe |
| rdy_n | output | 1 | Active-low data-ready |
| new_result | output | 1 | One-cycle strobe per output-register update |

## Verification
On every cycle, the assertions check the following local relations: the power-down response to a low sync input, the release of power-down, the fixed one-edge spacing from wake-up to filter reset to first sample, and the mutual exclusion of the strobes. They also check that ready is low whenever a result strobe fires. Other properties depend on the rate: the absolute settling length for each rate code, the four-cycle ready-high window and the result period. These, together with the capture of the rate on the wake-up edge and the abort-and-restart behaviour, are shown only by the bench. The bench sweeps every rate code and compares all outputs on every cycle against arithmetic expectations.

// File: rtl/wake_settle_pkg.sv
package wake_settle_pkg;

    typedef enum logic [1:0] {
        ST_PD     = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } seq_st_e;

endpackage

// File: rtl/wake_settle_cfg.sv
module wake_settle_cfg #(
    parameter int CFG_W       = 2,
    parameter int CNT_W       = 12,
    parameter int RATE_MIN    = 8,
    parameter int RATE_CODES  = 3,
    parameter int SETTLE_MULT = 74,
    parameter int SETTLE_OFS  = 2,
    parameter int EXTRA_DLY   = 2,
    parameter int RES_MULT    = 8
) (
    input  logic [CFG_W-1:0] sel,
    output logic [CNT_W-1:0] settle_len,
    output logic [CNT_W-1:0] period
);
    localparam int NCODE = 1 << CFG_W;

    logic [CNT_W-1:0] settle_tab [NCODE];
    logic [CNT_W-1:0] period_tab [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_code
        localparam int SHIFT = (g < RATE_CODES) ? g : RATE_CODES - 1;
        localparam int RATE  = RATE_MIN << SHIFT;
        assign settle_tab[g] = CNT_W'(RATE * SETTLE_MULT + SETTLE_OFS + EXTRA_DLY);
        assign period_tab[g] = CNT_W'(RATE * RES_MULT);
    end

    assign settle_len = settle_tab[sel];
    assign period     = period_tab[sel];

endmodule

// File: rtl/wake_settle_core.sv
module wake_settle_core
    import wake_settle_pkg::*;
#(
    parameter int CFG_W  = 2,
    parameter int CNT_W  = 12,
    parameter int RDY_HI = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pd_n,
    input  logic [CFG_W-1:0] sel_in,
    input  logic [CNT_W-1:0] settle_len,
    input  logic [CNT_W-1:0] period,
    output logic [CFG_W-1:0] sel_held,
    output logic             pwr_down,
    output logic             filt_rst,
    output logic             samp_take,
    output logic             rdy_n,
    output logic             new_result
);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] HI_LEN = CNT_W'(RDY_HI);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] sel;
        logic             pd;
        logic             frst;
        logic             samp;
        logic             rdy_n;
        logic             nres;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.frst = 1'b0;
        seq_d.samp = 1'b0;
        seq_d.nres = 1'b0;
        if (!sync_pd_n) begin
            seq_d.st    = ST_PD;
            seq_d.cnt   = '0;
            seq_d.pd    = 1'b1;
            seq_d.rdy_n = 1'b1;
        end else begin
            case (seq_q.st)
                ST_PD: begin
                    seq_d.st    = ST_SETTLE;
                    seq_d.cnt   = '0;
                    seq_d.sel   = sel_in;
                    seq_d.pd    = 1'b0;
                    seq_d.rdy_n = 1'b1;
                end
                ST_SETTLE: begin
                    seq_d.cnt  = seq_q.cnt + ONE;
                    seq_d.frst = (seq_q.cnt == '0);
                    seq_d.samp = (seq_q.cnt == ONE);
                    if (seq_q.cnt == settle_len - ONE) begin
                        seq_d.st    = ST_RUN;
                        seq_d.cnt   = '0;
                        seq_d.rdy_n = 1'b0;
                        seq_d.nres  = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (seq_q.cnt == period - ONE) begin
                        seq_d.cnt   = '0;
                        seq_d.rdy_n = 1'b0;
                        seq_d.nres  = 1'b1;
                    end else begin
                        seq_d.cnt   = seq_q.cnt + ONE;
                        seq_d.rdy_n = ((seq_q.cnt + ONE) >= (period - HI_LEN));
                    end
                end
                default: begin
                    seq_d.st    = ST_PD;
                    seq_d.pd    = 1'b1;
                    seq_d.rdy_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_PD;
            seq_q.pd    <= 1'b1;
            seq_q.rdy_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sel_held   = seq_q.sel;
    assign pwr_down   = seq_q.pd;
    assign filt_rst   = seq_q.frst;
    assign samp_take  = seq_q.samp;
    assign rdy_n      = seq_q.rdy_n;
    assign new_result = seq_q.nres;

endmodule

// File: rtl/wake_settle_seq.sv
module wake_settle_seq #(
    parameter int CFG_W       = 2,
    parameter int CNT_W       = 12,
    parameter int RATE_MIN    = 8,
    parameter int RATE_CODES  = 3,
    parameter int SETTLE_MULT = 74,
    parameter int SETTLE_OFS  = 2,
    parameter int EXTRA_DLY   = 2,
    parameter int RES_MULT    = 8,
    parameter int RDY_HI      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pd_n,
    input  logic [CFG_W-1:0] dec_sel,
    output logic             pwr_down,
    output logic             filt_rst,
    output logic             samp_take,
    output logic             rdy_n,
    output logic             new_result
);
    logic [CFG_W-1:0] sel_held;
    logic [CNT_W-1:0] settle_len;
    logic [CNT_W-1:0] period;

    wake_settle_cfg #(
        .CFG_W      (CFG_W),
        .CNT_W      (CNT_W),
        .RATE_MIN   (RATE_MIN),
        .RATE_CODES (RATE_CODES),
        .SETTLE_MULT(SETTLE_MULT),
        .SETTLE_OFS (SETTLE_OFS),
        .EXTRA_DLY  (EXTRA_DLY),
        .RES_MULT   (RES_MULT)
    ) u_cfg (
        .sel       (sel_held),
        .settle_len(settle_len),
        .period    (period)
    );

    wake_settle_core #(
        .CFG_W (CFG_W),
        .CNT_W (CNT_W),
        .RDY_HI(RDY_HI)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_pd_n (sync_pd_n),
        .sel_in    (dec_sel),
        .settle_len(settle_len),
        .period    (period),
        .sel_held  (sel_held),
        .pwr_down  (pwr_down),
        .filt_rst  (filt_rst),
        .samp_take (samp_take),
        .rdy_n     (rdy_n),
        .new_result(new_result)
    );

endmodule

// File: rtl/wake_settle_chk.sv
module wake_settle_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_pd_n,
    input logic pwr_down,
    input logic filt_rst,
    input logic samp_take,
    input logic rdy_n,
    input logic new_result
);
    AST_LOW_FORCES_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pd_n |=> (pwr_down && rdy_n)); // R2

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (rdy_n && !filt_rst && !samp_take && !new_result)); // R2

    AST_RELEASE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && sync_pd_n) |=> !pwr_down); // R3

    AST_WAKE_THEN_FRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_down) && sync_pd_n) |=> filt_rst); // R4

    AST_FRST_THEN_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_rst && sync_pd_n) |=> samp_take); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({filt_rst, samp_take, new_result})); // R4

    AST_RESULT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        new_result |-> !rdy_n); // R8
endmodule

bind wake_settle_seq wake_settle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_pd_n (sync_pd_n),
    .pwr_down  (pwr_down),
    .filt_rst  (filt_rst),
    .samp_take (samp_take),
    .rdy_n     (rdy_n),
    .new_result(new_result)
);

// File: tb/tb_wake_settle_seq.sv
`timescale 1ns/1ps
module tb_wake_settle_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pd_n = 1'b0;
    logic [1:0] dec_sel = 2'd0;
    logic       pwr_down, filt_rst, samp_take, rdy_n, new_result;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wake_settle_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_pd_n (sync_pd_n),
        .dec_sel   (dec_sel),
        .pwr_down  (pwr_down),
        .filt_rst  (filt_rst),
        .samp_take (samp_take),
        .rdy_n     (rdy_n),
        .new_result(new_result)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_pd(input string tag);
        chk({tag, " pwr_down"}, pwr_down, 1'b1);
        chk({tag, " rdy_n"}, rdy_n, 1'b1);
        chk({tag, " filt_rst"}, filt_rst, 1'b0);
        chk({tag, " samp_take"}, samp_take, 1'b0);
        chk({tag, " new_result"}, new_result, 1'b0);
    endtask

    // Hold sync low for n edges; every cycle must show power-down (R2, R9).
    task automatic hold_low(input int n);
        @(negedge clk);
        sync_pd_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_pd("R2/R9 low");
        end
    endtask

    // Release sync and compare every output on edges E0..E_kmax.
    task automatic wake_run(input logic [1:0] sel, input int kmax, input bit flip);
        int rate, t_set, per, m, ph;
        logic e_fr, e_sm, e_rdy, e_nr;
        rate  = (sel > 2'd2) ? 32 : (8 << sel);
        t_set = rate * 74 + 2 + 2;
        per   = rate * 8;
        @(negedge clk);
        dec_sel   = sel;
        sync_pd_n = 1'b1;
        for (int k = 0; k <= kmax; k++) begin
            @(negedge clk);
            e_fr = (k == 1);
            e_sm = (k == 2);
            if (k < t_set) begin
                e_rdy = 1'b1;
                e_nr  = 1'b0;
            end else begin
                m     = k - t_set;
                ph    = m % per;
                e_nr  = (ph == 0);
                e_rdy = (ph >= per - 4);
            end
            chk("R3 pwr_down", pwr_down, 1'b0);
            chk("R4 filt_rst", filt_rst, e_fr);
            chk("R5 samp_take", samp_take, e_sm);
            if (k <= t_set) chk("R6 rdy_n", rdy_n, e_rdy);
            else            chk("R7 rdy_n", rdy_n, e_rdy);
            chk("R8 new_result", new_result, e_nr);
            if (flip && k == 1) dec_sel = ~sel; // R10: late change ignored
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_pd("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_pd("R1 after reset");

        hold_low(3);
        for (int s = 0; s < 4; s++) begin
            int r, full;
            r    = (s > 2) ? 32 : (8 << s);
            full = r * 74 + 4 + 3 * r * 8 + 2;
            wake_run(2'(s), full, 1'b1);
            hold_low(2);
        end
        // R9: abort in mid-settling, then a full restart
        wake_run(2'd2, 1000, 1'b0);
        hold_low(2);
        // R9: abort right after filter reset
        wake_run(2'd1, 1, 1'b0);
        hold_low(1);
        wake_run(2'd0, 596 + 2 * 64 + 5, 1'b1);
        hold_low(1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule